// File: doc/BRIEF.md
# Sleep Clock-Gating Controller

This block sits beside the processor core and decides which clock domains run while the core sleeps. Software loads a small control word that holds a sleep-enable flag and a three-bit mode code. It then pulses a sleep request. The controller captures the mode at that moment and drops the enables for the core clock, the peripheral I/O clock, the converter clock, the asynchronous timer clock and the main oscillator, following the pattern that mode calls for.

Wake lines from the external pins, the asynchronous timer, the converter and the other I/O peripherals are qualified against the domains that are still running. A line whose domain is stopped cannot end the sleep. The external line always can. A qualifying wake brings the oscillator back first. In modes that had stopped the oscillator, the other clocks return only after a programmable startup count. In modes that kept the oscillator running, they return after a short fixed count. A hardware reset always leaves the controller fully awake.

Top module: `sleep_clkgate`

## Requirements
- R1: After reset, `awake` is 1, every enable output is 1, and the control word is cleared (sleep-enable 0, mode 0).
- R2: A sleep request while the sleep-enable bit is 0 is ignored. `awake` and all enables stay 1.
- R3: Mode code 0 (Idle) stops only the core clock. The peripheral I/O, converter and timer clocks and the oscillator stay on.
- R4: Mode code 1 (converter noise reduction) stops the core and peripheral I/O clocks. It keeps the converter clock, the timer clock and the oscillator on.
- R5: Mode code 2 (Power-down) stops every clock and the oscillator.
- R6: Mode code 3 (Power-save) behaves like Power-down except that the asynchronous timer clock stays on.
- R7: Mode code 6 (Standby) keeps only the oscillator on. Mode code 7 (Extended Standby) keeps the oscillator and the timer clock on.
- R8: The reserved mode codes 4 and 5 behave exactly as Idle.
- R9: While asleep, the external wake line always qualifies. The timer, converter and I/O wake lines qualify only when their own clock is enabled in the current mode. A wake that does not qualify leaves the controller asleep with its enables unchanged.
- R10: When waking from mode 2 or 3, `oscEn` rises on the cycle after the qualifying wake. `awake` and the full set of enables follow max(`startupCycles`,1) cycles after that.
- R11: When waking from a mode that keeps the oscillator on, `awake` returns FAST_WAKE cycles (default 2) after the qualifying wake is taken.
- R12: During the wake sequence the core clock stays off and further wake inputs have no effect. `awake` is 1 exactly when all five enables are 1.
- R13: The control word is written through `cfgWr` with `cfgData[3]` as sleep-enable and `cfgData[2:0]` as the mode. The mode is captured on sleep entry, so a write made while asleep does not change the current gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| cfgWr | input | 1 | Write strobe for the control word |
| cfgData | input | 4 | Control word: bit 3 sleep-enable, bits 2:0 mode |
| sleepReq | input | 1 | Single-cycle request to enter sleep |
| startupCycles | input | CNT_W | Oscillator startup count used after Power-down or Power-save |
| extWake | input | 1 | External pin wake request |
| timerWake | input | 1 | Asynchronous timer wake request |
| adcWake | input | 1 | Converter completion wake request |
| ioWake | input | 1 | Other peripheral wake request |
| cpuClkEn | output | 1 | Core clock enable |
| ioClkEn | output | 1 | Peripheral I/O clock enable |
| adcClkEn | output | 1 | Converter clock enable |
| asyClkEn | output | 1 | Asynchronous timer clock enable |
| oscEn | output | 1 | Main oscillator enable |
| awake | output | 1 | High when the core is running |

## Verification
All eight mode codes are driven with random wake vectors. Some vectors hold only non-qualifying lines, which separates a correct per-mode qualification from one that accepts any line. The other vectors mix qualifying lines in, and the wake latency is then counted cycle by cycle. This latency tells the oscillator-stopped modes, which use the programmed startup count, from the fast modes, which use the fixed count. Directed cases cover a request with sleep-enable clear, a startup count of 0 and 1, the reserved codes, and a control-word rewrite during sleep. Each of these would reveal a wrong mode capture or a missing clamp of the count.

// File: rtl/sleep_clkgate_pkg.sv
package sleep_clkgate_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ASLEEP = 2'd1,
    ST_WAKING = 2'd2
  } stateT;

  // one bit per gated domain
  typedef struct packed {
    logic osc;
    logic asy;
    logic adc;
    logic io;
    logic cpu;
  } gateT;

  // control -> datapath strobes
  typedef struct packed {
    logic latchMode;
    logic loadCnt;
    logic incCnt;
  } strobeT;

  localparam logic [2:0] MODE_IDLE   = 3'd0;
  localparam logic [2:0] MODE_ADCNR  = 3'd1;
  localparam logic [2:0] MODE_PDOWN  = 3'd2;
  localparam logic [2:0] MODE_PSAVE  = 3'd3;
  localparam logic [2:0] MODE_STBY   = 3'd6;
  localparam logic [2:0] MODE_XSTBY  = 3'd7;

  // gating pattern while asleep; reserved codes fall back to Idle
  function automatic gateT modePattern(input logic [2:0] mode);
    gateT g;
    case (mode)
      MODE_ADCNR: g = '{osc: 1'b1, asy: 1'b1, adc: 1'b1, io: 1'b0, cpu: 1'b0};
      MODE_PDOWN: g = '{osc: 1'b0, asy: 1'b0, adc: 1'b0, io: 1'b0, cpu: 1'b0};
      MODE_PSAVE: g = '{osc: 1'b0, asy: 1'b1, adc: 1'b0, io: 1'b0, cpu: 1'b0};
      MODE_STBY:  g = '{osc: 1'b1, asy: 1'b0, adc: 1'b0, io: 1'b0, cpu: 1'b0};
      MODE_XSTBY: g = '{osc: 1'b1, asy: 1'b1, adc: 1'b0, io: 1'b0, cpu: 1'b0};
      default:    g = '{osc: 1'b1, asy: 1'b1, adc: 1'b1, io: 1'b1, cpu: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/sleep_clkgate_datapath.sv
module sleep_clkgate_datapath
  import sleep_clkgate_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FAST_WAKE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [3:0]       cfgData,
  input  logic [CNT_W-1:0] startupCycles,
  input  logic             extWake,
  input  logic             timerWake,
  input  logic             adcWake,
  input  logic             ioWake,
  input  strobeT           strobe,
  output logic             sleepEn,
  output gateT             pattern,
  output logic             wakeOk,
  output logic             cntDone
);

  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_WAKE);

  logic             cfgEn;
  logic [2:0]       cfgMode;
  logic [2:0]       heldMode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // control word (R13)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      cfgMode <= '0;
    end else if (cfgWr) begin
      cfgEn   <= cfgData[3];
      cfgMode <= cfgData[2:0];
    end
  end

  assign sleepEn = cfgEn;

  // mode captured on sleep entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldMode <= '0;
    else if (strobe.latchMode) heldMode <= cfgMode;
  end

  assign pattern = modePattern(heldMode);

  // wake qualification: external always, others only if their domain runs (R9)
  assign wakeOk = extWake | (timerWake & pattern.asy) |
                  (adcWake & pattern.adc) | (ioWake & pattern.io);

  // wake delay counter (R10, R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      limit <= '0;
    end else if (strobe.loadCnt) begin
      cnt   <= '0;
      limit <= pattern.osc ? FAST_LIM : startupCycles;
    end else if (strobe.incCnt) begin
      cnt   <= cnt + 1'b1;
    end
  end

  // a limit of 0 behaves as 1
  assign cntDone = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incCnt |-> (({1'b0, cnt} + 1'b1) < {1'b0, limit}))
    else $error("wake counter stepped past its limit");

  assert_mode_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchMode |=> $stable(heldMode))
    else $error("held mode changed without a sleep entry");

endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
  import sleep_clkgate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sleepReq,
  input  logic   sleepEn,
  input  gateT   pattern,
  input  logic   wakeOk,
  input  logic   cntDone,
  output strobeT strobe,
  output gateT   gates,
  output logic   awake
);

  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_AWAKE: if (sleepReq && sleepEn) begin
        stateNext        = ST_ASLEEP;
        strobe.latchMode = 1'b1;
      end
      ST_ASLEEP: if (wakeOk) begin
        stateNext      = ST_WAKING;
        strobe.loadCnt = 1'b1;
      end
      ST_WAKING: if (cntDone) stateNext = ST_AWAKE;
                 else strobe.incCnt = 1'b1;
      default: stateNext = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= stateNext;
  end

  always_comb begin
    case (state)
      ST_ASLEEP: gates = pattern;
      ST_WAKING: begin
        gates     = pattern;
        gates.osc = 1'b1;
      end
      default:   gates = '1;
    endcase
  end

  assign awake = (state == ST_AWAKE);

  assert_awake_full_R12: assert property (@(posedge clk) disable iff (!rstN)
    awake |-> (gates == 5'b11111))
    else $error("awake with a gated domain");

  assert_cpu_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    !awake |-> !gates.cpu)
    else $error("core clock on while not awake");

  assert_ignore_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (awake && sleepReq && !sleepEn) |=> awake)
    else $error("sleep entered with sleep-enable clear");

  assert_hold_asleep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASLEEP && !wakeOk) |=> (state == ST_ASLEEP && $stable(gates)))
    else $error("left sleep without a qualifying wake");

  assert_osc_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASLEEP && wakeOk) |=> (gates.osc && !awake))
    else $error("oscillator not restored first on wake");

endmodule

// File: rtl/sleep_clkgate.sv
module sleep_clkgate
  import sleep_clkgate_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FAST_WAKE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [3:0]       cfgData,
  input  logic             sleepReq,
  input  logic [CNT_W-1:0] startupCycles,
  input  logic             extWake,
  input  logic             timerWake,
  input  logic             adcWake,
  input  logic             ioWake,
  output logic             cpuClkEn,
  output logic             ioClkEn,
  output logic             adcClkEn,
  output logic             asyClkEn,
  output logic             oscEn,
  output logic             awake
);

  strobeT strobe;
  gateT   pattern;
  gateT   gates;
  logic   sleepEn;
  logic   wakeOk;
  logic   cntDone;

  sleep_clkgate_datapath #(.CNT_W(CNT_W), .FAST_WAKE(FAST_WAKE)) u_datapath (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .startupCycles(startupCycles), .extWake(extWake), .timerWake(timerWake),
    .adcWake(adcWake), .ioWake(ioWake), .strobe(strobe), .sleepEn(sleepEn),
    .pattern(pattern), .wakeOk(wakeOk), .cntDone(cntDone)
  );

  sleep_clkgate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .sleepEn(sleepEn),
    .pattern(pattern), .wakeOk(wakeOk), .cntDone(cntDone),
    .strobe(strobe), .gates(gates), .awake(awake)
  );

  assign cpuClkEn = gates.cpu;
  assign ioClkEn  = gates.io;
  assign adcClkEn = gates.adc;
  assign asyClkEn = gates.asy;
  assign oscEn    = gates.osc;

endmodule

// File: tb/sleep_clkgate_bench.sv
module sleep_clkgate_bench;

  localparam int CNT_W = 8;
  localparam int FAST  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [3:0] cfgData = '0;
  logic sleepReq = 1'b0;
  logic [CNT_W-1:0] startupCycles = 8'd4;
  logic extWake = 1'b0, timerWake = 1'b0, adcWake = 1'b0, ioWake = 1'b0;
  logic cpuClkEn, ioClkEn, adcClkEn, asyClkEn, oscEn, awake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_clkgate #(.CNT_W(CNT_W), .FAST_WAKE(FAST)) u_sleep_clkgate (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .sleepReq(sleepReq), .startupCycles(startupCycles), .extWake(extWake),
    .timerWake(timerWake), .adcWake(adcWake), .ioWake(ioWake),
    .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn),
    .asyClkEn(asyClkEn), .oscEn(oscEn), .awake(awake)
  );

  // expected sleep pattern {osc,asy,adc,io,cpu}
  function automatic logic [4:0] expPattern(input logic [2:0] m);
    case (m)
      3'd1: return 5'b11100;
      3'd2: return 5'b00000;
      3'd3: return 5'b01000;
      3'd6: return 5'b10000;
      3'd7: return 5'b11000;
      default: return 5'b11110;
    endcase
  endfunction

  // wake vector {io,adc,timer,ext}
  function automatic bit expWake(input logic [2:0] m, input logic [3:0] w);
    logic [4:0] p;
    p = expPattern(m);
    return w[0] | (w[1] & p[3]) | (w[2] & p[2]) | (w[3] & p[1]);
  endfunction

  function automatic int expLatency(input logic [2:0] m, input int st);
    if (expPattern(m)[4]) return FAST;
    return (st < 1) ? 1 : st;
  endfunction

  function automatic logic [5:0] outs();
    return {awake, oscEn, asyClkEn, adcClkEn, ioClkEn, cpuClkEn};
  endfunction

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setWake(input logic [3:0] w);
    {ioWake, adcWake, timerWake, extWake} = w;
  endtask

  task automatic writeCfg(input logic [3:0] d);
    cfgWr = 1'b1; cfgData = d;
    step();
    cfgWr = 1'b0;
  endtask

  task automatic enterSleep(input logic [2:0] m, input string req);
    writeCfg({1'b1, m});
    sleepReq = 1'b1;
    step();
    sleepReq = 1'b0;
    check(req, outs(), {1'b0, expPattern(m)});
  endtask

  // wake edge has just been taken; walk the wake sequence
  task automatic followWake(input logic [2:0] m, input int st, input string req);
    int lat;
    lat = expLatency(m, st);
    check(req, outs(), {1'b0, expPattern(m) | 5'b10000});
    for (int i = 1; i < lat; i++) begin
      setWake(4'($urandom_range(0, 15)));  // ignored while waking (R12)
      step();
      check(req, outs(), {1'b0, expPattern(m) | 5'b10000});
    end
    step();
    check(req, outs(), 6'b111111);
    setWake(4'b0000);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    // R1: reset state
    check("R1", outs(), 6'b111111);
    rstN = 1'b1;
    step();
    check("R1", outs(), 6'b111111);

    // R2: request with sleep-enable clear (reset value, then explicit)
    sleepReq = 1'b1; step(); sleepReq = 1'b0;
    check("R2", outs(), 6'b111111);
    writeCfg(4'b0010);
    sleepReq = 1'b1; step(); sleepReq = 1'b0;
    check("R2", outs(), 6'b111111);
    step();
    check("R2", outs(), 6'b111111);

    // directed per-mode entries with an external wake
    startupCycles = 8'd5;
    enterSleep(3'd0, "R3");
    setWake(4'b0001); step(); followWake(3'd0, 5, "R11");
    enterSleep(3'd1, "R4");
    setWake(4'b1000); step();
    check("R9", outs(), 6'b011100);
    setWake(4'b0100); step(); followWake(3'd1, 5, "R11");
    enterSleep(3'd2, "R5");
    setWake(4'b1110); step();
    check("R9", outs(), 6'b000000);
    setWake(4'b0001); step(); followWake(3'd2, 5, "R10");
    enterSleep(3'd3, "R6");
    setWake(4'b0010); step(); followWake(3'd3, 5, "R10");
    enterSleep(3'd6, "R7");
    setWake(4'b0001); step(); followWake(3'd6, 5, "R11");
    enterSleep(3'd7, "R7");
    setWake(4'b0010); step(); followWake(3'd7, 5, "R11");
    enterSleep(3'd4, "R8");
    setWake(4'b1000); step(); followWake(3'd4, 5, "R8");
    enterSleep(3'd5, "R8");
    setWake(4'b0100); step(); followWake(3'd5, 5, "R8");

    // R10: startup count of 0 and 1 both give one cycle
    startupCycles = 8'd0;
    enterSleep(3'd2, "R10");
    setWake(4'b0001); step(); followWake(3'd2, 0, "R10");
    startupCycles = 8'd1;
    enterSleep(3'd3, "R10");
    setWake(4'b0001); step(); followWake(3'd3, 1, "R10");

    // R13: rewrite control word while asleep does not change gating
    startupCycles = 8'd3;
    enterSleep(3'd2, "R13");
    writeCfg(4'b1000);
    check("R13", outs(), 6'b000000);
    setWake(4'b1000); step();
    check("R13", outs(), 6'b000000);
    setWake(4'b0001); step(); followWake(3'd2, 3, "R13");

    // random phase
    for (int n = 0; n < 300; n++) begin
      logic [2:0] m;
      int st;
      bit woke;
      m = 3'($urandom_range(0, 7));
      st = $urandom_range(0, 20);
      startupCycles = CNT_W'(st);
      enterSleep(m, "R13");
      woke = 1'b0;
      for (int t = 0; t < 6 && !woke; t++) begin
        logic [3:0] w;
        w = 4'($urandom_range(0, 15));
        if (t == 5) w[0] = 1'b1;
        setWake(w);
        step();
        if (expWake(m, w)) begin
          woke = 1'b1;
          followWake(m, st, "R9");
        end else begin
          check("R9", outs(), {1'b0, expPattern(m)});
        end
      end
      if ($urandom_range(0, 3) == 0) begin
        writeCfg(4'($urandom_range(0, 7)));
        sleepReq = 1'b1; step(); sleepReq = 1'b0;
        check("R2", outs(), 6'b111111);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule